// File: doc/BRIEF.md
# Selectable Prescale Baud Tick Generator

This block produces the timing strobes that a serial transmitter and a serial receiver share. An 8-bit divisor X sets a reload counter that fires once every X+1 system clocks. A post-scaler after it gives the bit rate. In the asynchronous low-speed mode the bit rate is one bit per 64·(X+1) clocks. In the asynchronous high-speed mode it is one bit per 16·(X+1) clocks. In the synchronous mode it is one bit per 4·(X+1) clocks, and the speed select is ignored.

Two single-cycle strobes come out. The bit strobe marks each bit period. The oversample strobe marks sixteen equal slices of an asynchronous bit period and is used by a receiver to find edges and sample the line. Writing the divisor reloads the counter and clears the post-scale stages, so the new rate starts from a clean phase. The block is clocked by the system clock. Its reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `bitrate_tick_gen`

## Requirements
- R1: While `rst_n` is low, `os_tick` and `bit_tick` are both 0.
- R2: With `sync_sel`=0 and `fast_sel`=1 (asynchronous high speed), `os_tick` is high for one cycle every X+1 clocks. With X=0 it stays high on every cycle.
- R3: With `sync_sel`=0 and `fast_sel`=0 (asynchronous low speed), `os_tick` is high for one cycle every 4·(X+1) clocks.
- R4: In both asynchronous modes, `bit_tick` is high on every 16th `os_tick` and only together with it. This gives a bit period of 16·(X+1) clocks at high speed and 64·(X+1) clocks at low speed.
- R5: With `sync_sel`=1, `bit_tick` is high for one cycle every 4·(X+1) clocks whatever the value of `fast_sel`, and `os_tick` stays 0.
- R6: A clock edge with `div_wr`=1 loads X from `div_wdata`, restarts the counter and clears the post-scale phase. Counting that write edge as edge 0:
  - no tick follows edge 0;
  - the first `os_tick` follows edge P, where P is the oversample period;
  - the first `bit_tick` follows the edge that ends one full bit period.
- R7: The full divisor range 0 to 255 is honoured, including X=255 in low-speed mode (a bit period of 16384 clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_wr | input | 1 | Divisor write strobe; restarts the timer |
| div_wdata | input | 8 | New divisor value X |
| fast_sel | input | 1 | 1 = asynchronous high speed (/16), 0 = low speed (/64) |
| sync_sel | input | 1 | 1 = synchronous mode (/4), fast_sel ignored |
| os_tick | output | 1 | Oversample strobe, 16 per asynchronous bit period |
| bit_tick | output | 1 | Bit-period strobe |

## Verification
Both strobes come from registers. A strobe due on edge k of the divisor-counter sequence is therefore seen in the cycle that follows edge k. The write edge itself is edge 0, and no strobe follows it. The bench drives every write on a falling edge and counts rising edges from the write edge. It samples 1 ns after each rising edge and compares both outputs against periods it computes from X and the mode. Because each random run stops at an arbitrary phase before the next write, every run also tests that a write discards the phase already accumulated.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

  typedef enum logic [1:0] {
    RATE_ASYNC_SLOW = 2'd0,
    RATE_ASYNC_FAST = 2'd1,
    RATE_SYNC       = 2'd2
  } rate_mode_e;

  function automatic rate_mode_e decode_mode(input logic fast, input logic sync);
    if (sync)      return RATE_SYNC;
    else if (fast) return RATE_ASYNC_FAST;
    else           return RATE_ASYNC_SLOW;
  endfunction

endpackage

// File: rtl/bgen_rst_sync.sv
module bgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bgen_reload_cnt.sv
module bgen_reload_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] load_val,
  output logic         fire
);
  logic [W-1:0] div_q, div_d;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (restart) begin
      div_d = load_val;
      cnt_d = load_val;
    end else if (cnt_q == '0) begin
      fire  = 1'b1;
      cnt_d = div_q;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bgen_mod_cnt.sv
module bgen_mod_cnt #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic wrap
);
  localparam int W = (N > 2) ? $clog2(N) : 1;
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | adv;
    wrap   = adv & ~clr & (cnt_q == LAST);
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bitrate_tick_gen.sv
module bitrate_tick_gen #(
  parameter int DIV_W    = 8,
  parameter int OS_RATIO = 16,
  parameter int SLOW_PRE = 4,
  parameter int SYNC_PRE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             fast_sel,
  input  logic             sync_sel,
  output logic             os_tick,
  output logic             bit_tick
);
  import bgen_pkg::*;

  logic       rst_int_n;
  rate_mode_e mode;
  logic       pre_fire;
  logic       slow_wrap, sync_wrap, os_wrap;
  logic       os_evt, bit_evt;
  logic       os_tick_d, bit_tick_d;

  assign mode = decode_mode(fast_sel, sync_sel);

  bgen_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bgen_reload_cnt #(.W(DIV_W)) u_reload (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .restart  (div_wr),
    .load_val (div_wdata),
    .fire     (pre_fire)
  );

  generate
    if (SLOW_PRE == SYNC_PRE) begin : g_shared_pre
      logic shared_wrap;
      bgen_mod_cnt #(.N(SLOW_PRE)) u_pre (
        .clk   (clk),
        .rst_n (rst_int_n),
        .clr   (div_wr),
        .adv   (pre_fire & (mode != RATE_ASYNC_FAST)),
        .wrap  (shared_wrap)
      );
      assign slow_wrap = shared_wrap & (mode == RATE_ASYNC_SLOW);
      assign sync_wrap = shared_wrap & (mode == RATE_SYNC);
    end else begin : g_split_pre
      bgen_mod_cnt #(.N(SLOW_PRE)) u_pre_slow (
        .clk   (clk),
        .rst_n (rst_int_n),
        .clr   (div_wr),
        .adv   (pre_fire & (mode == RATE_ASYNC_SLOW)),
        .wrap  (slow_wrap)
      );
      bgen_mod_cnt #(.N(SYNC_PRE)) u_pre_sync (
        .clk   (clk),
        .rst_n (rst_int_n),
        .clr   (div_wr),
        .adv   (pre_fire & (mode == RATE_SYNC)),
        .wrap  (sync_wrap)
      );
    end
  endgenerate

  always_comb begin
    unique case (mode)
      RATE_ASYNC_FAST: os_evt = pre_fire;
      RATE_ASYNC_SLOW: os_evt = slow_wrap;
      default:         os_evt = 1'b0;
    endcase
  end

  bgen_mod_cnt #(.N(OS_RATIO)) u_os_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (div_wr),
    .adv   (os_evt),
    .wrap  (os_wrap)
  );

  always_comb begin
    bit_evt    = (mode == RATE_SYNC) ? sync_wrap : os_wrap;
    os_tick_d  = os_evt  & ~div_wr;
    bit_tick_d = bit_evt & ~div_wr;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      os_tick  <= os_tick_d;
      bit_tick <= bit_tick_d;
    end
  end
endmodule

// File: rtl/bgen_checks.sv
module bgen_checks #(
  parameter int DIV_W    = 8,
  parameter int SLOW_PRE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_wr,
  input logic [DIV_W-1:0] div_wdata,
  input logic             fast_sel,
  input logic             sync_sel,
  input logic             os_tick,
  input logic             bit_tick
);
  logic [DIV_W-1:0] div_sh;
  logic             fast_sh, sync_sh, armed;
  logic [15:0]      gap;
  logic [15:0]      os_per;

  always_comb os_per = 16'(({8'd0, div_sh} + 16'd1) * (fast_sh ? 16'd1 : 16'(SLOW_PRE)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sh  <= '0;
      fast_sh <= 1'b0;
      sync_sh <= 1'b0;
      armed   <= 1'b0;
      gap     <= '0;
    end else if (div_wr) begin
      div_sh  <= div_wdata;
      fast_sh <= fast_sel;
      sync_sh <= sync_sel;
      armed   <= 1'b1;
      gap     <= '0;
    end else if (os_tick) begin
      gap <= 16'd1;
    end else if (gap != 16'hffff) begin
      gap <= gap + 16'd1;
    end
  end

  always_comb begin
    if (!rst_n) a_reset_quiet_r1: assert (!os_tick && !bit_tick);
  end

  p_os_period_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !sync_sh && fast_sh && !div_wr) |-> (os_tick ? (gap == os_per) : (gap < os_per)));

  p_os_period_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !sync_sh && !fast_sh && !div_wr) |-> (os_tick ? (gap == os_per) : (gap < os_per)));

  p_bit_on_os_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !sync_sh && bit_tick) |-> os_tick);

  p_sync_no_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sync_sh) |-> !os_tick);

  p_write_silence_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (!os_tick && !bit_tick));

endmodule

bind bitrate_tick_gen bgen_checks #(.DIV_W(DIV_W), .SLOW_PRE(SLOW_PRE)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .div_wr    (div_wr),
  .div_wdata (div_wdata),
  .fast_sel  (fast_sel),
  .sync_sel  (sync_sel),
  .os_tick   (os_tick),
  .bit_tick  (bit_tick)
);

// File: tb/tb_bitrate_tick_gen.sv
`timescale 1ns/1ps
module tb_bitrate_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       div_wr;
  logic [7:0] div_wdata;
  logic       fast_sel, sync_sel;
  logic       os_tick, bit_tick;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  bitrate_tick_gen dut (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .fast_sel(fast_sel), .sync_sel(sync_sel), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  function automatic int os_period(int x, bit f, bit s);
    if (s) return 0;
    return f ? (x + 1) : 4 * (x + 1);
  endfunction

  function automatic int bit_period(int x, bit f, bit s);
    if (s) return 4 * (x + 1);
    return 16 * os_period(x, f, s);
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(int x, bit f, bit s, int n, string os_req, string bit_req);
    int osp = os_period(x, f, s);
    int bp  = bit_period(x, f, s);
    int os_bad = -1, bit_bad = -1, os_act = 0, bit_act = 0;
    bit os_exp, bit_exp;
    @(negedge clk);
    div_wr = 1'b1; div_wdata = 8'(x); fast_sel = f; sync_sel = s;
    @(posedge clk); #1;
    // R6: nothing follows the write edge
    check(!os_tick && !bit_tick, "R6", {os_tick, bit_tick}, 0, "ticks after write edge");
    @(negedge clk);
    div_wr = 1'b0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      os_exp  = (osp != 0) && (k % osp == 0);
      bit_exp = (k % bp == 0);
      if (os_tick !== os_exp && os_bad < 0)  begin os_bad = k;  os_act = os_tick;  end
      if (bit_tick !== bit_exp && bit_bad < 0) begin bit_bad = k; bit_act = bit_tick; end
    end
    check(os_bad < 0, os_req, os_act, os_bad < 0 ? 0 : int'(!os_act),
          $sformatf("os_tick at edge %0d (X=%0d f=%0d s=%0d)", os_bad, x, f, s));
    check(bit_bad < 0, bit_req, bit_act, bit_bad < 0 ? 0 : int'(!bit_act),
          $sformatf("bit_tick at edge %0d (X=%0d f=%0d s=%0d)", bit_bad, x, f, s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; div_wr = 1'b0; div_wdata = 8'd0; fast_sel = 1'b1; sync_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet in reset
    check(!os_tick && !bit_tick, "R1", {os_tick, bit_tick}, 0, "ticks during reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R2/R7: X=0 high speed, os_tick every cycle
    run_case(0, 1'b1, 1'b0, 40, "R2", "R4");
    // R2: small X, stopped mid-period, then restarted (R6)
    run_case(5, 1'b1, 1'b0, 150, "R2", "R4");
    run_case(5, 1'b1, 1'b0, 200, "R6", "R6");
    // R3: low speed
    run_case(2, 1'b0, 1'b0, 400, "R3", "R4");
    // R5: sync, fast_sel both values
    run_case(3, 1'b1, 1'b1, 70, "R5", "R5");
    run_case(3, 1'b0, 1'b1, 70, "R5", "R5");
    run_case(0, 1'b0, 1'b1, 20, "R5", "R5");
    // R7: largest divisor in slowest mode, two bit periods
    run_case(255, 1'b0, 1'b0, 2 * 16384 + 5, "R7", "R7");
    run_case(255, 1'b1, 1'b1, 2100, "R7", "R5");

    // random cases, each cut at an arbitrary phase (R6)
    for (int i = 0; i < 12; i++) begin
      int x = int'($urandom_range(0, 40));
      bit f = 1'($urandom_range(0, 1));
      bit s = ($urandom_range(0, 3) == 0);
      int n = 2 * bit_period(x, f, s) + int'($urandom_range(0, 30));
      run_case(x, f, s, n, s ? "R5" : (f ? "R2" : "R3"), s ? "R5" : "R4");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule